// File: doc/BRIEF.md
# Multiplexed LCD Segment Waveform Generator

This block drives a passive segment LCD with up to four backplanes and forty frontplanes. A small display store holds one bit per segment. A programmable prescaler splits time into backplane phases. For every pin the block emits a 2-bit code that picks which rung of the bias ladder to apply. An external analog stage turns those codes into voltages. The multiplex ratio (1/1 to 1/4) and the bias scheme (1/1, 1/2, 1/3) are selectable.

Each frame has two halves. In the second half every level is mirrored about the top of the ladder, so each segment sees no net DC. The host writes segment data through a valid/ready port, and that port never applies back-pressure. The host reads the store through a plain combinational port. Neither access ever stalls the waveform. The host writes one frontplane's backplane bits at a time. The picture changes only at phase boundaries, so no phase ever shows partial data.

Top module: `lcdmux_drive`

## Requirements
- R1: After reset all level outputs are 0 and every store entry reads back as 0.
- R2: Each backplane phase lasts `prescale`+1 clock cycles. Phases step through backplane 0 up to backplane `duty_sel`, after which the half-frame polarity flips and the sequence restarts at backplane 0.
- R3: Duty code `duty_sel`=d selects 1/(d+1) duty. Backplanes with an index greater than d drive level 0 at all times.
- R4: The top level M is 3 when `bias_sel` is 2 or 3. In the non-inverted half, the selected backplane drives 3 and the other active backplanes drive 1. A frontplane drives 0 when its segment bit for the current backplane is 1, and drives 2 otherwise.
- R5: With `bias_sel`=1 (M=2), the backplane levels are selected 2 and unselected 1, and the frontplane levels are on 0 and off 1. With `bias_sel`=0 (M=1), the backplane levels are selected 1 and unselected 0, and the frontplane levels are on 0 and off 1.
- R6: In the inverted half, every enabled level L is replaced by M−L.
- R7: A frontplane whose `fp_enable` bit is 0 drives the off level, mirrored in the inverted half, whatever its stored bits are.
- R8: While `enable` is 0, every output drives level 0. The phase sequence is held at backplane 0, non-inverted half, prescaler count 0.
- R9: `wr_ready` is always 1. A write is accepted in every cycle with `wr_valid` high. Writes to addresses of `NUM_FP` or above are dropped, and reads there return 0.
- R10: `rd_data` shows a write to the same address from the cycle after the write.
- R11: A write reaches the frontplane outputs only at the next phase boundary. The outputs inside the current phase keep the old data.
- R12: Store entry a holds frontplane a, and bit b of the entry is the segment at backplane b.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the waveform; 0 forces all levels to 0 |
| duty_sel | input | 2 | Active backplanes minus one |
| bias_sel | input | 2 | 0: 1/1, 1: 1/2, 2 or 3: 1/3 bias |
| prescale | input | 16 | Phase length minus one, in clock cycles |
| fp_enable | input | 40 | Per-frontplane drive enable |
| wr_valid | input | 1 | Write request |
| wr_ready | output | 1 | Write acceptance, tied high |
| wr_addr | input | 6 | Frontplane index written |
| wr_data | input | 4 | Segment bits, one per backplane |
| rd_addr | input | 6 | Frontplane index read |
| rd_data | output | 4 | Stored segment bits |
| bp_level | output | 8 | 2-bit level code per backplane, backplane i at bits 2i+1:2i |
| fp_level | output | 80 | 2-bit level code per frontplane, frontplane j at bits 2j+1:2j |

## Verification
The main function is exercised under four duty and bias pairs: 1/4 duty with 1/3 bias, 1/4 duty with 1/2 bias, 1/2 duty with 1/3 bias, and static drive. These runs separate mistakes in the level tables from mistakes in the phase sequencing and in the mirroring of the inverted half. A distinct per-frontplane bit pattern exposes swapped address or bit mapping. A write placed just after a phase boundary shows whether new data leaks into the running phase. Masking one frontplane and switching the block off confirm that the forced levels override the stored data.

// File: rtl/lcdmux_pkg.sv
package lcdmux_pkg;
  typedef logic [1:0] lvl_t;

  // top rung of the ladder for a bias code
  function automatic lvl_t top_of(input logic [1:0] bias);
    case (bias)
      2'd0:    top_of = 2'd1;
      2'd1:    top_of = 2'd2;
      default: top_of = 2'd3;
    endcase
  endfunction

  function automatic lvl_t bp_base(input logic [1:0] bias, input logic sel);
    if (sel)              bp_base = top_of(bias);
    else if (bias == 2'd0) bp_base = 2'd0;
    else                  bp_base = 2'd1;
  endfunction

  function automatic lvl_t fp_base(input logic [1:0] bias, input logic on);
    if (on)               fp_base = 2'd0;
    else if (bias[1])     fp_base = 2'd2;
    else                  fp_base = 2'd1;
  endfunction

  function automatic lvl_t mirror(input logic [1:0] bias, input lvl_t l, input logic inv);
    mirror = inv ? lvl_t'(top_of(bias) - l) : l;
  endfunction
endpackage

// File: rtl/lcdmux_phase_timer.sv
module lcdmux_phase_timer #(
  parameter int PRESC_W = 16,
  parameter int BP_W    = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic [PRESC_W-1:0] prescale,
  input  logic [BP_W-1:0]    duty_sel,
  output logic [BP_W-1:0]    bp_idx,
  output logic               half_inv,
  output logic               tick
);
  logic [PRESC_W-1:0] cnt_q;
  logic               last_bp;

  assign tick    = enable && (cnt_q == prescale);
  assign last_bp = (bp_idx >= duty_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      bp_idx   <= '0;
      half_inv <= 1'b0;
    end else if (!enable) begin
      cnt_q    <= '0;
      bp_idx   <= '0;
      half_inv <= 1'b0;
    end else if (tick) begin
      cnt_q <= '0;
      if (last_bp) begin
        bp_idx   <= '0;
        half_inv <= ~half_inv;
      end else begin
        bp_idx <= bp_idx + 1'b1;
      end
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/lcdmux_seg_store.sv
module lcdmux_seg_store #(
  parameter int NUM_FP = 40,
  parameter int NUM_BP = 4,
  parameter int ADDR_W = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [NUM_BP-1:0]        wr_data,
  input  logic [ADDR_W-1:0]        rd_addr,
  output logic [NUM_BP-1:0]        rd_data,
  input  logic                     load,
  output logic [NUM_FP*NUM_BP-1:0] shown_flat
);
  localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(NUM_FP);

  logic [NUM_BP-1:0] host_q  [NUM_FP];
  logic [NUM_BP-1:0] shown_q [NUM_FP];
  logic wr_ok, rd_ok;

  assign wr_ok = wr_en && ({1'b0, wr_addr} < LIMIT);
  assign rd_ok = ({1'b0, rd_addr} < LIMIT);
  assign rd_data = rd_ok ? host_q[rd_addr] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NUM_FP; k++) host_q[k] <= '0;
    end else if (wr_ok) begin
      host_q[wr_addr] <= wr_data;
    end
  end

  // display copy refreshed only at phase boundaries or while idle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NUM_FP; k++) shown_q[k] <= '0;
    end else if (load) begin
      for (int k = 0; k < NUM_FP; k++) shown_q[k] <= host_q[k];
    end
  end

  for (genvar g = 0; g < NUM_FP; g++) begin : g_flat
    assign shown_flat[g*NUM_BP +: NUM_BP] = shown_q[g];
  end
endmodule

// File: rtl/lcdmux_level_map.sv
module lcdmux_level_map
  import lcdmux_pkg::*;
#(
  parameter int NUM_FP = 40,
  parameter int NUM_BP = 4,
  parameter int BP_W   = 2
) (
  input  logic                     enable,
  input  logic [1:0]               bias_sel,
  input  logic [BP_W-1:0]          duty_sel,
  input  logic [BP_W-1:0]          bp_idx,
  input  logic                     half_inv,
  input  logic [NUM_FP-1:0]        fp_enable,
  input  logic [NUM_FP*NUM_BP-1:0] shown_flat,
  output logic [NUM_BP*2-1:0]      bp_level,
  output logic [NUM_FP*2-1:0]      fp_level
);
  logic phase_live;
  assign phase_live = (bp_idx <= duty_sel);

  for (genvar i = 0; i < NUM_BP; i++) begin : g_bp
    localparam logic [BP_W-1:0] IDX = BP_W'(i);
    logic active, sel;
    assign active = (IDX <= duty_sel);
    assign sel    = (bp_idx == IDX);
    assign bp_level[2*i +: 2] = (enable && active)
                              ? mirror(bias_sel, bp_base(bias_sel, sel), half_inv)
                              : 2'd0;
  end

  for (genvar j = 0; j < NUM_FP; j++) begin : g_fp
    logic [NUM_BP-1:0] row;
    logic on;
    assign row = shown_flat[j*NUM_BP +: NUM_BP];
    assign on  = fp_enable[j] && phase_live && row[bp_idx];
    assign fp_level[2*j +: 2] = enable
                              ? mirror(bias_sel, fp_base(bias_sel, on), half_inv)
                              : 2'd0;
  end
endmodule

// File: rtl/lcdmux_drive.sv
module lcdmux_drive #(
  parameter int NUM_FP  = 40,
  parameter int NUM_BP  = 4,
  parameter int PRESC_W = 16,
  parameter int ADDR_W  = $clog2(NUM_FP),
  parameter int BP_W    = $clog2(NUM_BP)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic [BP_W-1:0]     duty_sel,
  input  logic [1:0]          bias_sel,
  input  logic [PRESC_W-1:0]  prescale,
  input  logic [NUM_FP-1:0]   fp_enable,
  input  logic                wr_valid,
  output logic                wr_ready,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [NUM_BP-1:0]   wr_data,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [NUM_BP-1:0]   rd_data,
  output logic [NUM_BP*2-1:0] bp_level,
  output logic [NUM_FP*2-1:0] fp_level
);
  logic [BP_W-1:0]          bp_idx;
  logic                     half_inv;
  logic                     tick;
  logic [NUM_FP*NUM_BP-1:0] shown_flat;

  assign wr_ready = 1'b1;

  lcdmux_phase_timer #(.PRESC_W(PRESC_W), .BP_W(BP_W)) u_timer (
    .clk, .rst_n, .enable, .prescale, .duty_sel,
    .bp_idx, .half_inv, .tick
  );

  lcdmux_seg_store #(.NUM_FP(NUM_FP), .NUM_BP(NUM_BP), .ADDR_W(ADDR_W)) u_store (
    .clk, .rst_n,
    .wr_en (wr_valid),
    .wr_addr, .wr_data, .rd_addr, .rd_data,
    .load  (tick | ~enable),
    .shown_flat
  );

  lcdmux_level_map #(.NUM_FP(NUM_FP), .NUM_BP(NUM_BP), .BP_W(BP_W)) u_map (
    .enable, .bias_sel, .duty_sel, .bp_idx, .half_inv,
    .fp_enable, .shown_flat, .bp_level, .fp_level
  );
endmodule

// File: rtl/lcdmux_drive_chk.sv
module lcdmux_drive_chk #(
  parameter int NUM_FP = 40,
  parameter int NUM_BP = 4,
  parameter int ADDR_W = 6,
  parameter int BP_W   = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                enable,
  input logic [BP_W-1:0]     duty_sel,
  input logic [1:0]          bias_sel,
  input logic                wr_valid,
  input logic                wr_ready,
  input logic [ADDR_W-1:0]   wr_addr,
  input logic [NUM_BP-1:0]   wr_data,
  input logic [ADDR_W-1:0]   rd_addr,
  input logic [NUM_BP-1:0]   rd_data,
  input logic [NUM_BP*2-1:0] bp_level,
  input logic [NUM_FP*2-1:0] fp_level,
  input logic [BP_W-1:0]     bp_idx,
  input logic                half_inv,
  input logic                tick
);
  localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(NUM_FP);

  logic [NUM_BP*2-1:0] idle_mask;
  int unsigned         top_cnt;

  always_comb begin
    idle_mask = '0;
    top_cnt   = 0;
    for (int i = 0; i < NUM_BP; i++) begin
      if (i > int'(duty_sel)) idle_mask[2*i +: 2] = 2'b11;
      if (bp_level[2*i +: 2] == 2'd3) top_cnt++;
    end
  end

  // R8
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> (bp_level == '0 && fp_level == '0));

  // R9
  always_ready_chk: assert property (@(posedge clk) disable iff (!rst_n) wr_ready);

  // R3
  idle_bp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enable |-> ((bp_level & idle_mask) == '0));

  // R4
  one_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && bias_sel[1] && !half_inv && bp_idx <= duty_sel) |-> (top_cnt == 1));

  // R2
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(enable) && !$past(tick)) |-> ($stable(bp_idx) && $stable(half_inv)));

  // R10
  readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && ({1'b0, wr_addr} < LIMIT)) |=>
      (rd_addr != $past(wr_addr) || rd_data == $past(wr_data)));
endmodule

bind lcdmux_drive lcdmux_drive_chk #(
  .NUM_FP(NUM_FP), .NUM_BP(NUM_BP), .ADDR_W(ADDR_W), .BP_W(BP_W)
) u_chk (.*);

// File: tb/sim_lcdmux_drive.sv
`timescale 1ns/1ps
module sim_lcdmux_drive;
  localparam int NFP = 40;
  localparam int NBP = 4;

  logic clk = 0;
  logic rst_n = 0;
  logic enable = 0;
  logic [1:0] duty_sel = 2'd3;
  logic [1:0] bias_sel = 2'd2;
  logic [15:0] prescale = 16'd3;
  logic [NFP-1:0] fp_enable = '1;
  logic wr_valid = 0;
  logic wr_ready;
  logic [5:0] wr_addr = 0;
  logic [3:0] wr_data = 0;
  logic [5:0] rd_addr = 0;
  logic [3:0] rd_data;
  logic [NBP*2-1:0] bp_level;
  logic [NFP*2-1:0] fp_level;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit cmp_on = 0;

  always #2 clk = ~clk;

  lcdmux_drive u0 (
    .clk, .rst_n, .enable, .duty_sel, .bias_sel, .prescale, .fp_enable,
    .wr_valid, .wr_ready, .wr_addr, .wr_data, .rd_addr, .rd_data,
    .bp_level, .fp_level
  );

  // ---------------- reference model ----------------
  int m_cnt, m_bp, m_half;
  logic [3:0] m_ram [NFP];
  logic [3:0] m_shown [NFP];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_bp = 0; m_half = 0;
      for (int k = 0; k < NFP; k++) begin m_ram[k] = 0; m_shown[k] = 0; end
    end else begin
      if (!enable) begin
        m_cnt = 0; m_bp = 0; m_half = 0;
        for (int k = 0; k < NFP; k++) m_shown[k] = m_ram[k];
      end else if (m_cnt == int'(prescale)) begin
        m_cnt = 0;
        for (int k = 0; k < NFP; k++) m_shown[k] = m_ram[k];
        if (m_bp >= int'(duty_sel)) begin m_bp = 0; m_half = 1 - m_half; end
        else m_bp = m_bp + 1;
      end else begin
        m_cnt = m_cnt + 1;
      end
      if (wr_valid && wr_addr < NFP) m_ram[wr_addr] = wr_data;
    end
  end

  function automatic int top_lvl();
    if (bias_sel == 0) return 1;
    if (bias_sel == 1) return 2;
    return 3;
  endfunction

  function automatic int exp_bp(int i);
    int b;
    if (!enable || i > int'(duty_sel)) return 0;
    if (i == m_bp) b = top_lvl();
    else b = (bias_sel == 0) ? 0 : 1;
    return m_half ? top_lvl() - b : b;
  endfunction

  function automatic int exp_fp(int j);
    int b;
    bit on;
    if (!enable) return 0;
    on = fp_enable[j] && (m_bp <= int'(duty_sel)) && m_shown[j][m_bp];
    b = on ? 0 : ((bias_sel >= 2) ? 2 : 1);
    return m_half ? top_lvl() - b : b;
  endfunction

  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      string tag;
      int bad_pin, act, expv;
      bad_pin = -1; act = 0; expv = 0;
      tag = !enable ? "R8" : (m_half != 0 ? "R6" : (bias_sel >= 2 ? "R4" : "R5"));
      for (int i = 0; i < NBP; i++)
        if (bad_pin < 0 && int'(bp_level[2*i +: 2]) != exp_bp(i)) begin
          bad_pin = i; act = bp_level[2*i +: 2]; expv = exp_bp(i);
        end
      for (int j = 0; j < NFP; j++)
        if (bad_pin < 0 && int'(fp_level[2*j +: 2]) != exp_fp(j)) begin
          bad_pin = 100 + j; act = fp_level[2*j +: 2]; expv = exp_fp(j);
        end
      checks++;
      if (bad_pin >= 0) begin
        errors++;
        $display("FAIL %s pin %0d at cycle %0d: actual %0d expected %0d", tag, bad_pin, cycles, act, expv);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(string req, int actual, int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  task automatic hold(int n);
    for (int k = 0; k < n; k++) @(posedge clk);
    #1;
  endtask

  task automatic put(int a, int d);
    @(posedge clk); #1;
    wr_valid = 1; wr_addr = 6'(a); wr_data = 4'(d);
    @(posedge clk); #1;
    wr_valid = 0;
  endtask

  function automatic int pat(int a);
    return (a * 7 + 3) & 15;
  endfunction

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL R2 watchdog: actual %0d cycles expected completion", cycles);
      finish_run();
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    hold(4);
    rst_n = 1;
    cmp_on = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 bp", int'(bp_level), 0);
    chk("R1 fp", int'(|fp_level), 0);
    rd_addr = 6'd17;
    @(negedge clk);
    chk("R1 store", int'(rd_data), 0);

    // fill store; R9 ready and R10 readback
    for (int a = 0; a < NFP; a++) begin
      @(posedge clk); #1;
      wr_valid = 1; wr_addr = 6'(a); wr_data = 4'(pat(a));
      @(negedge clk);
      if (a == 5) chk("R9 ready", int'(wr_ready), 1);
    end
    @(posedge clk); #1;
    wr_valid = 0; rd_addr = 6'd5;
    @(negedge clk);
    chk("R10 readback", int'(rd_data), pat(5));
    put(45, 15);
    rd_addr = 6'd45;
    @(negedge clk);
    chk("R9 out of range read", int'(rd_data), 0);
    rd_addr = 6'd13;
    @(negedge clk);
    chk("R9 no alias", int'(rd_data), pat(13));

    // R2 phase length: prescale 3 -> 4 cycles on backplane 0
    @(posedge clk); #1;
    enable = 1;
    begin
      int len;
      len = 0;
      @(negedge clk);
      for (int k = 0; k < 50 && bp_level[1:0] == 2'd3; k++) begin
        len++;
        @(negedge clk);
      end
      chk("R2 phase length", len, 4);
      chk("R2 next backplane", int'(bp_level[3:2]), 3);
    end
    hold(70);

    // R11: write in the first cycle of a backplane-0 phase
    for (int k = 0; k < 100 && bp_level[1:0] == 2'd3; k++) @(negedge clk);
    for (int k = 0; k < 100 && bp_level[1:0] != 2'd3; k++) @(negedge clk);
    #1;
    wr_valid = 1; wr_addr = 6'd7; wr_data = 4'b0001;
    @(posedge clk); #1;
    wr_valid = 0;
    @(negedge clk);
    chk("R11 old data kept", int'(fp_level[15:14]), 2);

    // R12 bit mapping after a full frame
    for (int k = 0; k < 100 && bp_level[1:0] == 2'd3; k++) @(negedge clk);
    for (int k = 0; k < 100 && bp_level[1:0] != 2'd3; k++) @(negedge clk);
    chk("R12 bit0 on", int'(fp_level[15:14]), 0);
    for (int k = 0; k < 100 && bp_level[3:2] != 2'd3; k++) @(negedge clk);
    chk("R12 bit1 off", int'(fp_level[15:14]), 2);
    // R6 inverted half
    for (int k = 0; k < 100 && bp_level[1:0] != 2'd0; k++) @(negedge clk);
    chk("R6 inverted on", int'(fp_level[15:14]), 3);
    chk("R6 inverted unselected", int'(bp_level[3:2]), 2);

    // R7 masked frontplane
    @(posedge clk); #1;
    fp_enable[7] = 0;
    for (int k = 0; k < 100 && bp_level[1:0] != 2'd3; k++) @(negedge clk);
    chk("R7 masked", int'(fp_level[15:14]), 2);
    for (int k = 0; k < 100 && bp_level[1:0] != 2'd0; k++) @(negedge clk);
    chk("R7 masked inverted", int'(fp_level[15:14]), 1);
    @(posedge clk); #1;
    fp_enable[7] = 1;

    // R5 half bias
    bias_sel = 2'd1;
    for (int k = 0; k < 100 && bp_level[1:0] != 2'd2; k++) @(negedge clk);
    chk("R5 half bias selected", int'(bp_level[1:0]), 2);
    chk("R5 half bias unselected", int'(bp_level[3:2]), 1);
    hold(60);

    // R3 half duty with third bias
    @(posedge clk); #1;
    bias_sel = 2'd2; duty_sel = 2'd1;
    for (int k = 0; k < 6; k++) begin
      hold(7);
      @(negedge clk);
      chk("R3 idle backplanes", int'(bp_level[7:4]), 0);
    end

    // static drive, 1/1 bias
    @(posedge clk); #1;
    duty_sel = 2'd0; bias_sel = 2'd0; prescale = 16'd2;
    hold(40);
    @(negedge clk);
    chk("R3 static idle", int'(bp_level[7:2]), 0);

    // R8 disable
    @(posedge clk); #1;
    enable = 0;
    @(negedge clk);
    chk("R8 off bp", int'(bp_level), 0);
    chk("R8 off fp", int'(|fp_level), 0);
    hold(5);
    @(negedge clk);
    finish_run();
  end
endmodule